// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sets the cycle-level order of interrupt entry and exit for a small 8-bit processor core. The core has a 16-bit program counter and keeps its call stack in byte-wide data memory. The execution stage reports when an instruction finishes (`insn_bound`). It supplies the address of the next instruction and says whether the instruction now finishing is a return-from-interrupt. A separate arbiter presents one pending request and its vector address.

When a request is accepted, the sequencer holds the core for three cycles. In those cycles it stores the return address on the stack, low byte first. It moves the stack pointer down by two, clears the global interrupt enable, loads the vector into the program counter, and sends a one-cycle acknowledge back to the source. A return works the other way round: two reads from the stack (the memory has one cycle of read latency), then a program-counter load, with the enable set again. The block then keeps the core out of interrupts until one main-program instruction has finished. The stack pointer and the global enable are registers held inside the block. Software changes the enable through a write port.

Top module: `irq_seq`

## Requirements
- R1: After reset the enable reads 0 and the stack pointer equals `SP_INIT`. `stall`, `mem_we`, `mem_re`, `pc_load` and `vec_ack` are all low.
- R2: A request is accepted at an instruction boundary while the enable is 1 and no return is finishing. In the next cycle the block writes the low return-address byte at address SP. In the cycle after that it writes the high byte at SP-1. The stack pointer ends 2 lower.
- R3: Three cycles after acceptance, `pc_load` is high with `pc_new` equal to the latched vector, so the vector runs four cycles after the request was seen. The stack pointer has already dropped by 2 at that point.
- R4: While a request is pending and the current instruction has not finished, nothing is written and `stall` stays low. Entry starts in the cycle after the boundary.
- R5: A request is ignored while the enable is 0. Entry clears the enable, and it reads 0 when the vector loads.
- R6: A return reads address SP+1 in the cycle after its boundary and SP+2 in the next cycle. Three cycles after the boundary, `pc_new` = {first byte, second byte} with `pc_load` high. The stack pointer ends 2 higher and the enable reads 1 afterwards.
- R7: After a return, a pending request is not accepted before the boundary of the next main-program instruction. A boundary signalled during the return's load cycle is ignored.
- R8: `stall` is high in every push, vector, pop and load cycle, and only then. The memory is never read and written in the same cycle.
- R9: `vec_ack` is a single-cycle pulse, high only in the cycle the vector loads.
- R10: An enable write sets the enable to `ie_val` when the core is not stalled. The write is ignored during a stalled cycle.
- R11: If a return and a request meet at one boundary, the return runs and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | A prioritized request is pending |
| irq_vec | input | 16 | Vector address of the pending request |
| insn_bound | input | 1 | The current instruction finishes this cycle |
| reti_req | input | 1 | The finishing instruction is a return-from-interrupt |
| pc_cur | input | 16 | Address of the next instruction (return address) |
| ie_wr | input | 1 | Software write strobe for the global enable |
| ie_val | input | 1 | Value for the global enable write |
| gie | output | 1 | Global interrupt enable |
| sp | output | SP_W | Stack pointer |
| mem_we | output | 1 | Stack byte write |
| mem_re | output | 1 | Stack byte read (data returns next cycle) |
| mem_addr | output | SP_W | Stack access address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, one cycle after `mem_re` |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 16 | Vector or restored return address |
| vec_ack | output | 1 | Vector taken; the source clears its flag |
| stall | output | 1 | Hold the core |

## Verification
A return-from-interrupt and a newly pending request can arrive at the same instruction boundary. The bench raises the enable inside a handler, then drives `reti_req`, `irq_req` and `insn_bound` high together. It judges the result by the memory strobes: a read at SP+1 with no write shows the return won. The bench then keeps the request pending through the return. It checks that no push appears during the load cycle or before the next boundary, and that the push appears right after that boundary.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int SP_W = 16,
  parameter logic [SP_W-1:0] SP_INIT = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic [15:0]     irq_vec,
  input  logic            insn_bound,
  input  logic            reti_req,
  input  logic [15:0]     pc_cur,
  input  logic            ie_wr,
  input  logic            ie_val,
  output logic            gie,
  output logic [SP_W-1:0] sp,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            pc_load,
  output logic [15:0]     pc_new,
  output logic            vec_ack,
  output logic            stall
);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_PSHL, S_PSHH, S_VEC, S_POPH, S_POPL, S_HOLD
  } st_t;

  localparam logic [SP_W-1:0] ONE = SP_W'(1);

  st_t st, st_n;
  logic [15:0] ret_q, vec_q;
  logic [7:0]  hi_q;
  logic        ld_q;

  wire open_w = (st == S_IDLE) || (st == S_WAIT) || (st == S_HOLD && !ld_q);
  wire take   = irq_req && gie;
  wire accept = open_w && insn_bound && !reti_req && take;

  always_comb begin
    st_n = st;
    case (st)
      S_PSHL: st_n = S_PSHH;
      S_PSHH: st_n = S_VEC;
      S_VEC:  st_n = S_IDLE;
      S_POPH: st_n = S_POPL;
      S_POPL: st_n = S_HOLD;
      default: begin
        if (!open_w)          st_n = S_HOLD;
        else if (insn_bound)  st_n = reti_req ? S_POPH : (take ? S_PSHL : S_IDLE);
        else if (st != S_HOLD) st_n = take ? S_WAIT : S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sp    <= SP_INIT;
      gie   <= 1'b0;
      ld_q  <= 1'b0;
      hi_q  <= '0;
      ret_q <= '0;
      vec_q <= '0;
    end else begin
      st   <= st_n;
      ld_q <= (st == S_POPL);
      if (accept) begin
        ret_q <= pc_cur;
        vec_q <= irq_vec;
      end
      if (st == S_POPL) hi_q <= mem_rdata;
      if (mem_we) sp <= sp - ONE;
      if (mem_re) sp <= sp + ONE;
      if (st == S_PSHL)              gie <= 1'b0;
      else if (st == S_HOLD && ld_q) gie <= 1'b1;
      else if (open_w && ie_wr)      gie <= ie_val;
    end
  end

  assign mem_we    = (st == S_PSHL) || (st == S_PSHH);
  assign mem_re    = (st == S_POPH) || (st == S_POPL);
  assign mem_addr  = mem_re ? sp + ONE : sp;
  assign mem_wdata = (st == S_PSHL) ? ret_q[7:0] : ret_q[15:8];
  assign vec_ack   = (st == S_VEC);
  assign pc_load   = vec_ack || (st == S_HOLD && ld_q);
  assign pc_new    = vec_ack ? vec_q : {hi_q, mem_rdata};
  assign stall     = !open_w;

  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> !vec_ack);

  a_r2_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PSHL) |=> mem_we && mem_addr == $past(mem_addr) - ONE);

  a_r5_gie_off_at_vec: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |-> !gie);

  a_r6_gie_on_after_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !vec_ack) |=> gie);

  a_r8_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r3_sp_down2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |-> sp == $past(sp, 3) - SP_W'(2));

  a_r7_no_push_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !vec_ack) |=> !mem_we);

endmodule

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
  logic clk = 0, rst_n = 0;
  logic irq_req = 0, insn_bound = 0, reti_req = 0, ie_wr = 0, ie_val = 0;
  logic [15:0] irq_vec = 0, pc_cur = 0;
  logic gie, mem_we, mem_re, pc_load, vec_ack, stall;
  logic [7:0] sp, mem_addr, mem_wdata, mem_rdata;
  logic [15:0] pc_new;
  logic [7:0] mem [256];
  int total = 0, bad = 0;
  logic [7:0] exp_sp;

  always #10 clk = ~clk;

  irq_seq #(.SP_W(8), .SP_INIT(8'hFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .insn_bound(insn_bound), .reti_req(reti_req), .pc_cur(pc_cur),
    .ie_wr(ie_wr), .ie_val(ie_val), .gie(gie), .sp(sp),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_load(pc_load),
    .pc_new(pc_new), .vec_ack(vec_ack), .stall(stall));

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic set_gie();
    ie_wr = 1; ie_val = 1; tick(); ie_wr = 0;
    chk(gie == 1'b1, "R10 enable write", gie, 1);
  endtask

  task automatic do_entry(input logic [15:0] ret, input logic [15:0] vec, input int waitk);
    pc_cur = ret; irq_vec = vec; irq_req = 1; insn_bound = 0;
    for (int k = 0; k < waitk; k++) begin
      tick();
      chk(!mem_we && !stall, "R4 wait for boundary", {mem_we, stall}, 0);
    end
    insn_bound = 1; tick(); insn_bound = 0;
    chk(mem_we && mem_addr == exp_sp && mem_wdata == ret[7:0] && stall,
        "R2 low byte push", {mem_addr, mem_wdata}, {exp_sp, ret[7:0]});
    ie_wr = 1; ie_val = 1; tick(); ie_wr = 0;
    chk(mem_we && mem_addr == exp_sp - 8'd1 && mem_wdata == ret[15:8],
        "R2 high byte push", {mem_addr, mem_wdata}, {exp_sp - 8'd1, ret[15:8]});
    chk(gie == 1'b0, "R10 write ignored while stalled / R5 cleared", gie, 0);
    tick();
    exp_sp = exp_sp - 8'd2;
    chk(pc_load && vec_ack && pc_new == vec && stall, "R3 vector load", pc_new, vec);
    chk(sp == exp_sp, "R3 sp lowered", sp, exp_sp);
    chk(gie == 1'b0, "R5 enable off at vector", gie, 0);
    irq_req = 0; tick();
    chk(!vec_ack && !pc_load && !stall, "R9 ack single pulse", {vec_ack, pc_load, stall}, 0);
  endtask

  task automatic do_ret(input logic [15:0] exp_pc, input bit pend);
    if (pend) begin
      set_gie();
      irq_req = 1; pc_cur = 16'hA55A; irq_vec = 16'h0042;
    end
    reti_req = 1; insn_bound = 1; tick(); reti_req = 0;
    chk(mem_re && !mem_we && mem_addr == exp_sp + 8'd1 && stall,
        pend ? "R11 return wins" : "R6 first pop", mem_addr, exp_sp + 8'd1);
    tick();
    chk(mem_re && mem_addr == exp_sp + 8'd2, "R6 second pop", mem_addr, exp_sp + 8'd2);
    tick();
    chk(pc_load && !vec_ack && pc_new == exp_pc && stall, "R6 pc restore", pc_new, exp_pc);
    insn_bound = 0; tick();
    exp_sp = exp_sp + 8'd2;
    chk(!mem_we && !stall && gie && sp == exp_sp, "R7/R6 after return",
        {mem_we, stall, gie, sp}, {3'b001, exp_sp});
    if (pend) begin
      tick();
      chk(!mem_we && !stall, "R7 held before boundary", mem_we, 0);
      insn_bound = 1; tick(); insn_bound = 0;
      chk(mem_we && mem_addr == exp_sp && mem_wdata == 8'h5A, "R7 entry after one insn",
          {mem_addr, mem_wdata}, {exp_sp, 8'h5A});
      tick(); tick();
      chk(vec_ack && pc_new == 16'h0042, "R3 vector after hold", pc_new, 16'h0042);
      irq_req = 0; tick();
      exp_sp = exp_sp - 8'd2;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_sp = 8'hFF;
    repeat (3) @(posedge clk);
    #5 rst_n = 1; #2;
    chk(!gie && sp == 8'hFF && !stall && !mem_we && !mem_re && !pc_load && !vec_ack,
        "R1 reset state", {gie, sp}, {1'b0, 8'hFF});
    irq_req = 1; insn_bound = 1; tick(); tick();
    chk(!mem_we && !stall, "R5 gated when disabled", {mem_we, stall}, 0);
    irq_req = 0; insn_bound = 0; tick();
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 3; j++) begin
        logic [15:0] r, v;
        r = 16'h1234 * (k * 3 + j + 1) + 16'h00F1;
        v = 16'h0002 << (k + j);
        set_gie();
        do_entry(r, v, k);
        do_ret(r, 0);
      end
    end
    set_gie();
    do_entry(16'hBEEF, 16'h0004, 1);
    set_gie();
    do_entry(16'hCAFE, 16'h0006, 0);
    do_ret(16'hCAFE, 0);
    do_ret(16'hBEEF, 1);
    do_ret(16'hA55A, 0);
    chk(sp == 8'hFF, "R6 stack balanced", sp, 8'hFF);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule